// File: doc/BRIEF.md
# FIFO Flag Offset Configuration Controller

This block prepares the four threshold offsets used by the almost-full and almost-empty flags of a bidirectional FIFO pair. The FIFO pair has one FIFO per direction. Each FIFO has a full-side offset and an empty-side offset. The block captures a two-bit select code on the clock edges while reset is held low. The value seen on the last such edge picks the configuration style for the whole session.

Three of the four codes load every offset with a fixed preset during reset. The input port then becomes ready a short, fixed delay after reset is released. The remaining code selects programming over the port-A write path. The offsets are then taken from the data bus one qualified write at a time, in a fixed order. The port stays not-ready until the fourth offset has been captured. After that the configuration is frozen until the next reset.

All logic runs on the port-A clock. The FIFO storage, the flag comparators and any clock-domain crossing sit outside this block.

Top module: `flag_cfg_ctrl`

## Requirements
- R1: The select code is captured on every rising edge while `rst_n` is low. The value from the last such edge governs the session. Changes of `flag_sel` after reset is released have no effect on the offsets or on the ready timing.
- R2: Select code 2'b01 loads all four offsets with the value 8.
- R3: Select code 2'b10 loads all four offsets with 16, and code 2'b11 loads all four with 64.
- R4: Select code 2'b00 selects bus programming. All four offsets read 0 until written.
- R5: A write is qualified only in a cycle where `wr_en`=1, `cs_n`=0, `wr_rd`=1 and `mbx_sel`=0. Unqualified cycles neither load an offset nor advance the sequence, and qualified writes need not be consecutive.
- R6: In programming mode, successive qualified writes load `full_ofs1`, then `empty_ofs1`, then `full_ofs2`, then `empty_ofs2`. Each write takes its value from `din[OFS_W-1:0]` and drops the upper data bits.
- R7: `cfg_ready` is 0 throughout reset and while programming is incomplete. In programming mode it goes to 1 on the same clock edge that captures the fourth offset.
- R8: In a preset mode, `cfg_ready` goes to 1 on the second rising edge after `rst_n` goes high (READY_DLY=2) and is 0 after the first.
- R9: Once `cfg_ready` is 1, further writes are ignored and the offsets keep their values until the next reset.
- R10: `cfg_ready` stays 1 until reset is applied again.
- R11: A new reset re-captures the select code and configures the block afresh. This also holds when a programming sequence was left part-way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port-A clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_sel | input | 2 | Offset configuration select, captured during reset |
| wr_en | input | 1 | Port-A write enable |
| cs_n | input | 1 | Port-A chip select, active low |
| wr_rd | input | 1 | Port-A direction, 1 = write |
| mbx_sel | input | 1 | Mailbox select, must be 0 for an offset write |
| din | input | DATA_W (36) | Port-A data bus |
| full_ofs1 | output | OFS_W (16) | Almost-full offset of FIFO 1 |
| empty_ofs1 | output | OFS_W (16) | Almost-empty offset of FIFO 1 |
| full_ofs2 | output | OFS_W (16) | Almost-full offset of FIFO 2 |
| empty_ofs2 | output | OFS_W (16) | Almost-empty offset of FIFO 2 |
| cfg_ready | output | 1 | Configuration done; port-A input ready, sticky until reset |

## Verification
The bench builds the block with its default parameters: a 36-bit bus, 16-bit offsets, a ready delay of two cycles and presets of 8, 16 and 64. These values make every preset distinguishable from the others and from zero. The data words carry nonzero upper bits, so a write that failed to truncate to 16 bits would show at the outputs. The two-cycle delay keeps the gap between the not-ready and ready edges short enough to check on exact cycles. Programming runs interleave every kind of unqualified write between the qualified ones. They also cut one sequence short with a new reset.

// File: rtl/flag_cfg_pkg.sv
// Package: shared types for the flag offset configuration controller.
// Assumes: four offsets, slot order fixed by the write sequence.
package flag_cfg_pkg;

    // Select codes captured during reset
    typedef enum logic [1:0] {
        SEL_PROGRAM = 2'b00,
        SEL_PRE_LO  = 2'b01,
        SEL_PRE_MID = 2'b10,
        SEL_PRE_HI  = 2'b11
    } sel_e;

    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    // Slot index in write order: this order is behaviour
    typedef enum logic [SLOT_W-1:0] {
        SLOT_FULL1  = 2'd0,
        SLOT_EMPTY1 = 2'd1,
        SLOT_FULL2  = 2'd2,
        SLOT_EMPTY2 = 2'd3
    } slot_e;

endpackage

// File: rtl/flag_cfg_mode_latch.sv
// Module: flag_cfg_mode_latch
// Captures the select code on every edge while reset is low and holds it
// afterwards. Assumes rst_n is synchronous to clk.
module flag_cfg_mode_latch
    import flag_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_in,
    output sel_e       mode_q,
    output logic       is_program
);

    // Track the select input during reset, freeze it afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= sel_e'(sel_in);
        end
    end

    // Programming mode decode
    always_comb begin
        is_program = (mode_q == SEL_PROGRAM);
    end

    // The captured mode never moves between resets
    assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

endmodule

// File: rtl/flag_cfg_seq.sv
// Module: flag_cfg_seq
// Write sequencer and ready generator. In programming mode it steps a slot
// pointer on each qualified write and finishes after the last slot. In preset
// mode it counts READY_DLY edges after reset release. Assumes READY_DLY >= 1.
module flag_cfg_seq
    import flag_cfg_pkg::*;
#(
    parameter int READY_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_program,
    input  logic              wr_ok,
    output logic              wr_stb,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              done
);

    localparam int CNT_W = $clog2(READY_DLY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READY_DLY - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

    logic [CNT_W-1:0] dly_cnt;

    // Offset write strobe: programming mode, qualified, not yet done
    always_comb begin
        wr_stb = is_program && wr_ok && !done;
    end

    // Slot pointer advances once per accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot <= '0;
        end else if (wr_stb) begin
            wr_slot <= wr_slot + 1'b1;
        end
    end

    // Preset-mode delay counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_cnt <= '0;
        end else if (!is_program && !done && dly_cnt != CNT_LAST) begin
            dly_cnt <= dly_cnt + 1'b1;
        end
    end

    // Sticky completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (!done) begin
            if (is_program) begin
                done <= wr_stb && (wr_slot == SLOT_LAST);
            end else begin
                done <= (dly_cnt == CNT_LAST);
            end
        end
    end

    // Completion is never withdrawn outside reset
    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // Preset mode never moves the slot pointer
    assert_no_slot_in_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !is_program |-> (wr_slot == '0));

    // In programming mode, completion coincides with a wrap of the pointer
    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_program && $rose(done)) |-> (wr_slot == '0));

endmodule

// File: rtl/flag_cfg_ofs_regs.sv
// Module: flag_cfg_ofs_regs
// Four offset registers. During reset each loads the preset for the select
// code on the bus (zero for programming mode). Afterwards a slot is written
// from the low data bits when the sequencer strobes it.
module flag_cfg_ofs_regs
    import flag_cfg_pkg::*;
#(
    parameter int DATA_W  = 36,
    parameter int OFS_W   = 16,
    parameter int PRE_LO  = 8,
    parameter int PRE_MID = 16,
    parameter int PRE_HI  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel_in,
    input  logic              wr_stb,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] din,
    output logic [OFS_W-1:0]  ofs_q [NUM_SLOTS]
);

    logic [OFS_W-1:0] preset_val;

    // Preset value chosen by the select code currently on the pins
    always_comb begin
        unique case (sel_e'(sel_in))
            SEL_PRE_LO:  preset_val = OFS_W'(PRE_LO);
            SEL_PRE_MID: preset_val = OFS_W'(PRE_MID);
            SEL_PRE_HI:  preset_val = OFS_W'(PRE_HI);
            default:     preset_val = '0;
        endcase
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // One offset register: preset in reset, bus load when addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ofs_q[g] <= preset_val;
            end else if (wr_stb && wr_slot == SLOT_W'(g)) begin
                ofs_q[g] <= din[OFS_W-1:0];
            end
        end
    end

endmodule

// File: rtl/flag_cfg_ctrl.sv
// Module: flag_cfg_ctrl (top)
// Sets up the almost-full/almost-empty offsets of a FIFO pair after reset,
// from a preset or from four ordered writes, and gates port-A ready until done.
// Assumes a single clock (port A) and synchronous active-low reset.
module flag_cfg_ctrl
    import flag_cfg_pkg::*;
#(
    parameter int DATA_W    = 36,
    parameter int OFS_W     = 16,
    parameter int READY_DLY = 2,
    parameter int PRE_LO    = 8,
    parameter int PRE_MID   = 16,
    parameter int PRE_HI    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        flag_sel,
    input  logic              wr_en,
    input  logic              cs_n,
    input  logic              wr_rd,
    input  logic              mbx_sel,
    input  logic [DATA_W-1:0] din,
    output logic [OFS_W-1:0]  full_ofs1,
    output logic [OFS_W-1:0]  empty_ofs1,
    output logic [OFS_W-1:0]  full_ofs2,
    output logic [OFS_W-1:0]  empty_ofs2,
    output logic              cfg_ready
);

    sel_e              mode_q;
    logic              is_program;
    logic              wr_ok;
    logic              wr_stb;
    logic [SLOT_W-1:0] wr_slot;
    logic              done;
    logic [OFS_W-1:0]  ofs_q [NUM_SLOTS];

    // Qualify a port-A offset write
    always_comb begin
        wr_ok = wr_en && !cs_n && wr_rd && !mbx_sel;
    end

    flag_cfg_mode_latch u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_in     (flag_sel),
        .mode_q     (mode_q),
        .is_program (is_program)
    );

    flag_cfg_seq #(
        .READY_DLY (READY_DLY)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_program (is_program),
        .wr_ok      (wr_ok),
        .wr_stb     (wr_stb),
        .wr_slot    (wr_slot),
        .done       (done)
    );

    flag_cfg_ofs_regs #(
        .DATA_W  (DATA_W),
        .OFS_W   (OFS_W),
        .PRE_LO  (PRE_LO),
        .PRE_MID (PRE_MID),
        .PRE_HI  (PRE_HI)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_in  (flag_sel),
        .wr_stb  (wr_stb),
        .wr_slot (wr_slot),
        .din     (din),
        .ofs_q   (ofs_q)
    );

    // Drive the outputs in write order
    always_comb begin
        full_ofs1  = ofs_q[SLOT_FULL1];
        empty_ofs1 = ofs_q[SLOT_EMPTY1];
        full_ofs2  = ofs_q[SLOT_FULL2];
        empty_ofs2 = ofs_q[SLOT_EMPTY2];
        cfg_ready  = done;
    end

    // Assertion-only cycle counter since reset release, saturating
    localparam int SINCE_W = $clog2(READY_DLY + 1) + 1;
    logic [SINCE_W-1:0] since_rst;

    // Count edges after reset release for the ready-delay check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != SINCE_W'(READY_DLY)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    assert_preset_ready_on_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_program && since_rst == SINCE_W'(READY_DLY)) |-> cfg_ready);

    assert_preset_ready_not_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_program && since_rst != SINCE_W'(READY_DLY)) |-> !cfg_ready);

    assert_frozen_after_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> ($stable(full_ofs1) && $stable(empty_ofs1) &&
                       $stable(full_ofs2) && $stable(empty_ofs2)));

    assert_preset_lo_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEL_PRE_LO) |-> (full_ofs1 == OFS_W'(PRE_LO) && empty_ofs2 == OFS_W'(PRE_LO)));

    assert_preset_hi_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEL_PRE_HI) |-> (empty_ofs1 == OFS_W'(PRE_HI) && full_ofs2 == OFS_W'(PRE_HI)));

endmodule

// File: tb/flag_cfg_ctrl_bench.sv
// Bench for flag_cfg_ctrl: a behavioural reference model steps on every
// rising edge and is compared with the outputs on every falling edge.
module flag_cfg_ctrl_bench;

    localparam int DATA_W = 36;
    localparam int OFS_W  = 16;
    localparam int MASK   = (1 << OFS_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        flag_sel = 2'b01;
    logic              wr_en = 1'b0;
    logic              cs_n = 1'b1;
    logic              wr_rd = 1'b0;
    logic              mbx_sel = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic [OFS_W-1:0]  full_ofs1, empty_ofs1, full_ofs2, empty_ofs2;
    logic              cfg_ready;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done_run = 1'b0;

    always #5 clk = ~clk;

    flag_cfg_ctrl u_flag_cfg_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_sel   (flag_sel),
        .wr_en      (wr_en),
        .cs_n       (cs_n),
        .wr_rd      (wr_rd),
        .mbx_sel    (mbx_sel),
        .din        (din),
        .full_ofs1  (full_ofs1),
        .empty_ofs1 (empty_ofs1),
        .full_ofs2  (full_ofs2),
        .empty_ofs2 (empty_ofs2),
        .cfg_ready  (cfg_ready)
    );

    // Reference model state
    int  m_mode = 0;
    int  m_ofs [4] = '{0, 0, 0, 0};
    int  m_idx = 0;
    int  m_cnt = 0;
    int  m_ready = 0;
    bit  m_valid = 1'b0;

    function automatic int preset_of(int code);
        case (code)
            1: return 8;
            2: return 16;
            3: return 64;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Model step on every rising edge
    always @(posedge clk) begin
        cycles++;
        m_valid = 1'b1;
        if (!rst_n) begin
            m_mode = int'(flag_sel);
            for (int i = 0; i < 4; i++) m_ofs[i] = preset_of(m_mode);
            m_idx = 0;
            m_cnt = 0;
            m_ready = 0;
        end else if (m_ready == 0) begin
            if (m_mode == 0) begin
                if (wr_en && !cs_n && wr_rd && !mbx_sel) begin
                    m_ofs[m_idx] = int'(din) & MASK;
                    if (m_idx == 3) m_ready = 1;
                    m_idx++;
                end
            end else begin
                m_cnt++;
                if (m_cnt == 2) m_ready = 1;
            end
        end
    end

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (m_valid && !done_run) begin
            string otag;
            if (m_mode == 0) otag = (m_ready != 0) ? "R9" : "R6";
            else if (m_mode == 1) otag = "R2";
            else otag = "R3";
            check(otag, int'(full_ofs1),  m_ofs[0]);
            check(otag, int'(empty_ofs1), m_ofs[1]);
            check(otag, int'(full_ofs2),  m_ofs[2]);
            check(otag, int'(empty_ofs2), m_ofs[3]);
            check((m_mode == 0 || !rst_n) ? "R7" : "R8", int'(cfg_ready), m_ready);
        end
    end

    // One cycle with the given port-A controls
    task automatic cyc(bit en, bit cs, bit wr, bit mb, logic [DATA_W-1:0] d);
        wr_en = en; cs_n = cs; wr_rd = wr; mbx_sel = mb; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, '0);
    endtask

    task automatic do_reset(logic [1:0] code);
        rst_n = 1'b0;
        flag_sel = code;
        idle(3);
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            done_run = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // Reset state and preset 8; select changes right after release (R1)
        rst_n = 1'b0; flag_sel = 2'b11; idle(1);
        flag_sel = 2'b01; idle(2);
        check("R7", int'(cfg_ready), 0);
        rst_n = 1'b1;
        flag_sel = 2'b00;
        idle(1);
        check("R8", int'(cfg_ready), 0);
        idle(1);
        check("R8", int'(cfg_ready), 1);
        check("R1", int'(full_ofs1), 8);
        check("R2", int'(empty_ofs2), 8);
        // Qualified writes in preset mode have no effect (R9)
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 36'h0_0000_0ABC);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 36'h0_0000_0DEF);
        check("R9", int'(full_ofs1), 8);
        check("R10", int'(cfg_ready), 1);

        // Presets 16 and 64 with re-reset (R3, R11)
        do_reset(2'b10);
        idle(3);
        check("R3", int'(empty_ofs1), 16);
        check("R11", int'(cfg_ready), 1);
        do_reset(2'b11);
        idle(3);
        check("R3", int'(full_ofs2), 64);

        // Programming mode with interleaved unqualified writes (R4, R5, R6)
        do_reset(2'b00);
        check("R4", int'(full_ofs1), 0);
        check("R4", int'(cfg_ready), 0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 36'hF_0000_1111);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 36'hF_0000_2222);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 36'hF_0000_3333);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 36'hF_0000_4444);
        check("R5", int'(full_ofs1), 0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 36'hA_0001_0011);
        check("R6", int'(full_ofs1), 16'h0011);
        idle(2);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 36'h5_0000_0022);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 36'h5_0000_7777);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 36'h3_FFFF_0033);
        check("R5", int'(empty_ofs1), 16'h0022);
        check("R7", int'(cfg_ready), 0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 36'hC_1234_0044);
        check("R7", int'(cfg_ready), 1);
        check("R6", int'(full_ofs2), 16'h0033);
        check("R6", int'(empty_ofs2), 16'h0044);
        // Extra writes after completion (R9, R10)
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 36'h0_0000_0055);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 36'h0_0000_0066);
        check("R9", int'(full_ofs1), 16'h0011);
        check("R10", int'(cfg_ready), 1);

        // Abandoned sequence then new preset reset (R11)
        do_reset(2'b00);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 36'h0_0000_0101);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 36'h0_0000_0202);
        check("R11", int'(cfg_ready), 0);
        do_reset(2'b01);
        idle(2);
        check("R11", int'(empty_ofs1), 8);
        check("R11", int'(cfg_ready), 1);
        // Restart programming from slot 0 after a fresh reset (R11)
        do_reset(2'b00);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 36'h0_0000_0909);
        check("R11", int'(full_ofs1), 16'h0909);
        check("R11", int'(empty_ofs1), 0);

        done_run = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule